// File: doc/BRIEF.md
# Link Compliance Test Pattern Generator

This block produces the serial bit streams that a multi-lane display-link transmitter sends while its physical layer is being measured for compliance. Each lane gives one bit per clock together with a valid strobe. A two-bit select picks one of four patterns:

- a PRBS7 sequence;
- a half-rate clock (alternating ones and zeros);
- a divide-by-five clock;
- an 80-bit composite pattern built from three run-length segments.

The lane count is a parameter (1, 2 or 4 in practice). Every enabled lane carries the selected pattern. A per-lane seed offset can make the PRBS streams differ between lanes.

A restart pulse, or any change of the select, makes every enabled lane start its pattern again from the first bit at the next clock edge. A lane whose enable is low drives zeros, drops its strobe and keeps its position, so it can be paused and resumed.

The clock and composite patterns come from a sequencer state machine. Its states are:

- SQ_PRBS: idle while the PRBS pattern is selected.
- SQ_HALF: alternating bits.
- SQ_DIV5: ten-bit unit, five ones then five zeros.
- SQ_RUN: the first composite segment, ten-bit units.
- SQ_QUAD: the second composite segment, four-bit units.
- SQ_ALT: the third composite segment, two-bit units.

Its transitions are:

- load: any state goes to the start state of the selected pattern.
- SQ_RUN goes to SQ_QUAD after its third unit.
- SQ_QUAD goes to SQ_ALT after its eighth unit.
- SQ_ALT goes back to SQ_RUN after its ninth unit.
- SQ_HALF, SQ_DIV5 and SQ_PRBS stay where they are.

Top module: `lcpg_top`

## Requirements
- R1: While reset is asserted, every lane drives `lane_bit` = 0 and `lane_vld` = 0.
- R2: Select encoding: 2'b00 = PRBS7, 2'b01 = half-rate clock, 2'b10 = divide-by-five clock, 2'b11 = composite. A lane enabled at a clock edge shows `lane_vld` = 1 and the next bit of the selected pattern after that edge.
- R3: PRBS7 is a 7-bit shift register with next state {s[5:0], s[6]^s[5]} (x^7 + x^6 + 1). The output bit is s[6]. The first bit after a start is the seed's MSB, and the stream repeats every 127 bits.
- R4: The seed of lane k is (PRBS_SEED + k*SEED_STEP) mod 128, with a zero result replaced by 1.
- R5: The half-rate pattern is 1,0,1,0,... starting with 1.
- R6: The divide-by-five pattern is five ones then five zeros, repeated.
- R7: The composite pattern is 3 units of (five ones, five zeros), then 8 units of (1,1,0,0), then 9 units of (1,0). That gives 80 bits, which then repeat.
- R8: If restart is high, or the select differs from the pattern the lane last produced, at an edge where the lane is enabled, the bit after that edge is the pattern's first bit.
- R9: A lane disabled at an edge drives bit 0 and valid 0 after it, and its pattern position is unchanged. A restart seen only while it is disabled has no effect on it. After re-enable with the same select, it continues from where it stopped.
- R10: A PRBS7 stream never shows more than six consecutive zeros, so the all-zero register state is never reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of all enabled lanes |
| pat_sel | input | 2 | Pattern select |
| lane_en | input | LANES | Per-lane enable |
| lane_bit | output | LANES | Per-lane serial output bit |
| lane_vld | output | LANES | Per-lane bit-valid strobe |

## Verification
Each pattern runs for more than two of its periods on all four lanes. A long PRBS run separates a correct feedback tap and per-lane seed from a wrong one. The composite run crosses every segment boundary, which exposes off-by-one unit counts. Directed sequences follow:

- a select change without restart, which tells a mode-driven reload apart from a restart-only reload;
- a restart in the middle of the composite pattern;
- one lane paused across a restart pulse, which shows that its position is frozen rather than reset.

// File: rtl/lcpg_pkg.sv
`timescale 1ns/1ps
package lcpg_pkg;

    localparam int PRBS_W = 7;
    localparam int PRBS_TAP = 6;

    typedef enum logic [1:0] {
        PAT_PRBS7 = 2'b00,
        PAT_HALF  = 2'b01,
        PAT_DIV5  = 2'b10,
        PAT_COMP  = 2'b11
    } pat_e;

    typedef enum logic [2:0] {
        SQ_PRBS,
        SQ_HALF,
        SQ_DIV5,
        SQ_RUN,
        SQ_QUAD,
        SQ_ALT
    } sq_e;

    localparam int HALF_LEN  = 2;
    localparam int DIV5_LEN  = 10;
    localparam int RUN_LEN   = 10;
    localparam int RUN_REPS  = 3;
    localparam int QUAD_LEN  = 4;
    localparam int QUAD_REPS = 8;
    localparam int ALT_LEN   = 2;
    localparam int ALT_REPS  = 9;
    localparam int IDX_W     = 4;
    localparam int REP_W     = 4;

    function automatic logic [PRBS_W-1:0] lane_seed(
        input logic [PRBS_W-1:0] base,
        input logic [PRBS_W-1:0] step,
        input int                k
    );
        logic [PRBS_W-1:0] s;
        s = base + PRBS_W'(int'(step) * k);
        if (s == '0) s = PRBS_W'(1);
        return s;
    endfunction

endpackage

// File: rtl/lcpg_prbs.sv
`timescale 1ns/1ps
module lcpg_prbs #(
    parameter int               WIDTH = lcpg_pkg::PRBS_W,
    parameter int               TAP   = lcpg_pkg::PRBS_TAP,
    parameter logic [WIDTH-1:0] SEED  = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic bit_o
);
    logic [WIDTH-1:0] st_q;
    logic [WIDTH-1:0] cur;
    logic             fb;

    always_comb begin
        cur = load ? SEED : st_q;
        fb  = cur[WIDTH-1] ^ cur[TAP-1];
    end

    assign bit_o = cur[WIDTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else if (step) begin
            st_q <= {cur[WIDTH-2:0], fb};
        end
    end
endmodule

// File: rtl/lcpg_seq.sv
`timescale 1ns/1ps
module lcpg_seq
    import lcpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  pat_e pat,
    output logic bit_o
);
    localparam logic [IDX_W-1:0] HALF_L = IDX_W'(HALF_LEN);
    localparam logic [IDX_W-1:0] DIV5_L = IDX_W'(DIV5_LEN);
    localparam logic [IDX_W-1:0] RUN_L  = IDX_W'(RUN_LEN);
    localparam logic [IDX_W-1:0] QUAD_L = IDX_W'(QUAD_LEN);
    localparam logic [IDX_W-1:0] ALT_L  = IDX_W'(ALT_LEN);
    localparam logic [REP_W-1:0] RUN_N  = REP_W'(RUN_REPS);
    localparam logic [REP_W-1:0] QUAD_N = REP_W'(QUAD_REPS);
    localparam logic [REP_W-1:0] ALT_N  = REP_W'(ALT_REPS);

    sq_e              st_q, cur_st, nxt_st;
    logic [IDX_W-1:0] idx_q, cur_idx, nxt_idx, unit_len;
    logic [REP_W-1:0] rep_q, cur_rep, nxt_rep;
    logic             unit_end;

    // Effective state for this cycle: a load jumps straight to the pattern start.
    always_comb begin
        if (load) begin
            unique case (pat)
                PAT_PRBS7: cur_st = SQ_PRBS;
                PAT_HALF:  cur_st = SQ_HALF;
                PAT_DIV5:  cur_st = SQ_DIV5;
                PAT_COMP:  cur_st = SQ_RUN;
                default:   cur_st = SQ_PRBS;
            endcase
            cur_idx = '0;
            cur_rep = '0;
        end else begin
            cur_st  = st_q;
            cur_idx = idx_q;
            cur_rep = rep_q;
        end
    end

    // Next state.
    always_comb begin
        unique case (cur_st)
            SQ_HALF: unit_len = HALF_L;
            SQ_DIV5: unit_len = DIV5_L;
            SQ_RUN:  unit_len = RUN_L;
            SQ_QUAD: unit_len = QUAD_L;
            SQ_ALT:  unit_len = ALT_L;
            default: unit_len = IDX_W'(1);
        endcase
        unit_end = (cur_idx == unit_len - IDX_W'(1));
        nxt_idx  = unit_end ? '0 : cur_idx + IDX_W'(1);
        nxt_st   = cur_st;
        nxt_rep  = cur_rep;
        if (unit_end) begin
            unique case (cur_st)
                SQ_RUN: begin
                    if (cur_rep == RUN_N - REP_W'(1)) begin
                        nxt_st  = SQ_QUAD;
                        nxt_rep = '0;
                    end else begin
                        nxt_rep = cur_rep + REP_W'(1);
                    end
                end
                SQ_QUAD: begin
                    if (cur_rep == QUAD_N - REP_W'(1)) begin
                        nxt_st  = SQ_ALT;
                        nxt_rep = '0;
                    end else begin
                        nxt_rep = cur_rep + REP_W'(1);
                    end
                end
                SQ_ALT: begin
                    if (cur_rep == ALT_N - REP_W'(1)) begin
                        nxt_st  = SQ_RUN;
                        nxt_rep = '0;
                    end else begin
                        nxt_rep = cur_rep + REP_W'(1);
                    end
                end
                default: begin
                    nxt_st  = cur_st;
                    nxt_rep = '0;
                end
            endcase
        end
    end

    // Output: the first half of every unit is high.
    always_comb begin
        unique case (cur_st)
            SQ_HALF: bit_o = (cur_idx < (HALF_L >> 1));
            SQ_DIV5: bit_o = (cur_idx < (DIV5_L >> 1));
            SQ_RUN:  bit_o = (cur_idx < (RUN_L  >> 1));
            SQ_QUAD: bit_o = (cur_idx < (QUAD_L >> 1));
            SQ_ALT:  bit_o = (cur_idx < (ALT_L  >> 1));
            default: bit_o = 1'b0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_PRBS;
            idx_q <= '0;
            rep_q <= '0;
        end else if (step) begin
            st_q  <= nxt_st;
            idx_q <= nxt_idx;
            rep_q <= nxt_rep;
        end
    end
endmodule

// File: rtl/lcpg_lane.sv
`timescale 1ns/1ps
module lcpg_lane
    import lcpg_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  pat_e pat_sel,
    output logic bit_o,
    output logic vld_o
);
    pat_e mode_q;
    logic load, prbs_bit, seq_bit, nxt_bit;

    assign load = restart || (pat_sel != mode_q);

    lcpg_prbs #(
        .WIDTH (PRBS_W),
        .TAP   (PRBS_TAP),
        .SEED  (SEED)
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (en && (pat_sel == PAT_PRBS7)),
        .bit_o (prbs_bit)
    );

    lcpg_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (en),
        .pat   (pat_sel),
        .bit_o (seq_bit)
    );

    assign nxt_bit = (pat_sel == PAT_PRBS7) ? prbs_bit : seq_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PAT_PRBS7;
            bit_o  <= 1'b0;
            vld_o  <= 1'b0;
        end else if (en) begin
            mode_q <= pat_sel;
            bit_o  <= nxt_bit;
            vld_o  <= 1'b1;
        end else begin
            bit_o  <= 1'b0;
            vld_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/lcpg_top.sv
`timescale 1ns/1ps
module lcpg_top
    import lcpg_pkg::*;
#(
    parameter int                LANES     = 4,
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h7F,
    parameter logic [PRBS_W-1:0] SEED_STEP = 7'd23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [1:0]       pat_sel,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] lane_bit,
    output logic [LANES-1:0] lane_vld
);
    pat_e sel;
    assign sel = pat_e'(pat_sel);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [PRBS_W-1:0] LSEED = lane_seed(PRBS_SEED, SEED_STEP, k);
        lcpg_lane #(
            .SEED (LSEED)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (lane_en[k]),
            .restart (restart),
            .pat_sel (sel),
            .bit_o   (lane_bit[k]),
            .vld_o   (lane_vld[k])
        );
    end
endmodule

// File: rtl/lcpg_checker.sv
`timescale 1ns/1ps
module lcpg_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic [1:0]       pat_sel,
    input logic [LANES-1:0] lane_en,
    input logic [LANES-1:0] lane_bit,
    input logic [LANES-1:0] lane_vld
);
    logic [1:0] age_q;
    logic       primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assign primed = (age_q == 2'd3);

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        logic       live_q;
        logic [3:0] zrun_q;

        // live_q: the bit now on the output continues a PRBS stream
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= 1'b0;
                zrun_q <= '0;
            end else begin
                live_q <= lane_en[i] && (pat_sel == 2'b00) && !restart;
                if (live_q && !lane_bit[i]) begin
                    if (zrun_q != 4'hF) zrun_q <= zrun_q + 4'd1;
                end else begin
                    zrun_q <= '0;
                end
            end
        end

        assert_valid_follows_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_en[i] |=> lane_vld[i]);

        assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[i] |=> (!lane_vld[i] && !lane_bit[i]));

        assert_restart_first_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en[i] && restart && (pat_sel != 2'b00)) |=> lane_bit[i]);

        assert_half_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && lane_en[i] && $past(lane_en[i]) && !restart &&
             (pat_sel == 2'b01) && ($past(pat_sel) == 2'b01))
            |=> (lane_bit[i] != $past(lane_bit[i])));

        assert_prbs_zero_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
            zrun_q <= 4'd6);
    end
endmodule

bind lcpg_top lcpg_checker #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .pat_sel  (pat_sel),
    .lane_en  (lane_en),
    .lane_bit (lane_bit),
    .lane_vld (lane_vld)
);

// File: tb/lcpg_top_tb.sv
`timescale 1ns/1ps
module lcpg_top_tb;
    localparam int         LANES = 4;
    localparam logic [6:0] BASE  = 7'h7F;
    localparam logic [6:0] STEP  = 7'd23;
    localparam int         VEC_N = 7;
    // entry: {pattern select, number of bits}
    localparam logic [10:0] VEC [VEC_N] = '{
        {2'b00, 9'd260}, {2'b01, 9'd20}, {2'b10, 9'd35}, {2'b11, 9'd170},
        {2'b00, 9'd30},  {2'b11, 9'd90}, {2'b01, 9'd9}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             restart;
    logic [1:0]       pat_sel;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_bit;
    logic [LANES-1:0] lane_vld;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [6:0] m_lfsr [LANES];
    int         m_idx  [LANES];
    logic [1:0] m_mode [LANES];
    int         zrun   [LANES];
    int         zmax   [LANES];

    always #2.5 clk = ~clk;

    lcpg_top #(.LANES(LANES), .PRBS_SEED(BASE), .SEED_STEP(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .pat_sel(pat_sel),
        .lane_en(lane_en), .lane_bit(lane_bit), .lane_vld(lane_vld)
    );

    function automatic logic [6:0] seed_of(input int k);
        int s;
        s = (int'(BASE) + k * int'(STEP)) % 128;
        if (s == 0) s = 1;
        return 7'(s);
    endfunction

    function automatic logic clk_ref(input logic [1:0] p, input int k);
        int q;
        case (p)
            2'b01:   return (k % 2) == 0;
            2'b10:   return (k % 10) < 5;
            default: begin
                q = k % 80;
                if (q < 30)      return (q % 10) < 5;
                else if (q < 62) return ((q - 30) % 4) < 2;
                else             return ((q - 62) % 2) == 0;
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] p);
        case (p)
            2'b00:   return "R3/R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input int l, input logic ab, input logic av,
                         input logic eb, input logic ev);
        n_checks++;
        if (ab !== eb || av !== ev) begin
            n_fail++;
            $display("FAIL %s lane %0d: bit=%b vld=%b expected bit=%b vld=%b",
                     tag, l, ab, av, eb, ev);
        end
    endtask

    task automatic cycle(input logic rs, input logic [1:0] p, input logic [LANES-1:0] en,
                         input string tag);
        logic eb;
        @(negedge clk);
        restart = rs;
        pat_sel = p;
        lane_en = en;
        @(posedge clk);
        #1;
        for (int l = 0; l < LANES; l++) begin
            if (en[l]) begin
                if (rs || p != m_mode[l]) begin
                    m_mode[l] = p;
                    m_idx[l]  = 0;
                    m_lfsr[l] = seed_of(l);
                end
                if (p == 2'b00) begin
                    eb = m_lfsr[l][6];
                    m_lfsr[l] = {m_lfsr[l][5:0], m_lfsr[l][6] ^ m_lfsr[l][5]};
                    if (rs) zrun[l] = 0;
                    if (lane_bit[l] == 1'b0) zrun[l]++;
                    else zrun[l] = 0;
                    if (zrun[l] > zmax[l]) zmax[l] = zrun[l];
                end else begin
                    eb = clk_ref(p, m_idx[l]);
                    m_idx[l]++;
                    zrun[l] = 0;
                end
                check(tag, l, lane_bit[l], lane_vld[l], eb, 1'b1);
            end else begin
                zrun[l] = 0;
                check(tag, l, lane_bit[l], lane_vld[l], 1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        restart = 1'b0;
        pat_sel = 2'b00;
        lane_en = '0;
        for (int l = 0; l < LANES; l++) begin
            m_lfsr[l] = seed_of(l);
            m_idx[l]  = 0;
            m_mode[l] = 2'b00;
            zrun[l]   = 0;
            zmax[l]   = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        for (int l = 0; l < LANES; l++)
            check("R1", l, lane_bit[l], lane_vld[l], 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: all lanes disabled after reset
        cycle(1'b0, 2'b00, '0, "R9");

        // Table walk: every pattern, restarted, over more than two periods (R2)
        for (int t = 0; t < VEC_N; t++) begin
            for (int k = 0; k < int'(VEC[t][8:0]); k++)
                cycle(k == 0, VEC[t][10:9], '1, tag_of(VEC[t][10:9]));
        end

        // R8: select change without restart reloads the new pattern
        repeat (3)  cycle(1'b0, 2'b01, '1, "R8");
        repeat (12) cycle(1'b0, 2'b10, '1, "R8");
        repeat (25) cycle(1'b0, 2'b11, '1, "R8");
        // R8: restart inside the composite pattern
        cycle(1'b1, 2'b11, '1, "R8");
        repeat (12) cycle(1'b0, 2'b11, '1, "R8");

        // R9: pause lane 2 across a restart, then resume where it stopped
        repeat (2) cycle(1'b0, 2'b11, 4'b1011, "R9");
        cycle(1'b1, 2'b11, 4'b1011, "R9");
        repeat (3) cycle(1'b0, 2'b11, 4'b1011, "R9");
        repeat (15) cycle(1'b0, 2'b11, '1, "R9");
        // R9: pause in PRBS, resume same select
        repeat (5) cycle(1'b1, 2'b00, '1, "R9");
        repeat (4) cycle(1'b0, 2'b00, 4'b0110, "R9");
        repeat (10) cycle(1'b0, 2'b00, '1, "R9");

        // R10: no PRBS zero run longer than six
        for (int l = 0; l < LANES; l++) begin
            n_checks++;
            if (zmax[l] > 6 || zmax[l] == 0) begin
                n_fail++;
                $display("FAIL R10 lane %0d: longest zero run=%0d expected 1..6", l, zmax[l]);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule